// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and delivers them to a processor on two outputs: a fast-interrupt line and a normal-interrupt line. Each request can be enabled or disabled, steered to either output, or raised by software. For the normal path, a bank of vector slots maps chosen request lines to handler entry addresses. The block keeps a current-service priority level, so software can jump straight to the handler of the most urgent pending source.

Software reads the vector-address register to claim the winning request. That read returns the handler address and raises the in-service level to that request's priority, which holds back equal and lower-priority requests. A request that is enabled and steered to the normal output, but that no enabled slot selects, is served through one programmable default address at the lowest priority. Software clears the request at its source and then writes any value to the vector-address register. That write ends service, restores the previous level and, if work is still pending, raises the normal output again on the same clock edge.

Top module: `pvic_top`

## Requirements
- R1: After reset, both outputs are low, all enables, software triggers, fast selects and slot controls read zero, and a vector-address read (word offset 0x08) with nothing pending returns the default address, which resets to zero.
- R2: An enabled request whose fast-select bit (offset 0x03) is 1 drives only the fast output. With that bit at 0 it drives only the normal output. A disabled request drives neither output.
- R3: A request line that is first sampled high at clock edge k raises its output at edge k+2. A software trigger written at edge k raises its output at edge k+1.
- R4: A vector-address read returns the address register (offset 0x20+n) of the lowest-numbered eligible slot n. A slot's control word (offset 0x30+n) holds the enable at bit 8 and the source number in its low bits. The slot is eligible when it is enabled, its source is enabled and normal-routed and pending, and n is below the current service level.
- R5: When pending, enabled, normal-routed requests exist but no enabled slot selects any of them, a vector-address read returns the default address register (offset 0x09). The default level ranks below every slot.
- R6: A vector-address read that claims a request drops the normal output on that same edge. Afterwards, requests of equal or lower priority do not raise it.
- R7: A request of higher priority than the one in service raises the normal output and can be claimed. Its acknowledge restores the previous level, which still holds back requests of that level and below.
- R8: A write of any value to offset 0x08 ends the current service. If an eligible request is pending, the normal output is high after that same edge.
- R9: Writing ones to offset 0x04 sets enable bits and writing ones to offset 0x05 clears them. Zero bits leave enables unchanged. Reading offset 0x04 returns the enables.
- R10: Writing ones to offset 0x06 sets software trigger bits and writing ones to offset 0x07 clears them. A trigger acts as a request. Offset 0x00 reads the OR of the synchronized lines and the triggers.
- R11: Offset 0x01 reads the pending requests that are enabled and fast-routed, and offset 0x02 reads those that are enabled and normal-routed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | N_SRC | Level-sensitive request lines |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (claims on a vector-address read) |
| bus_addr_i | input | 6 | Register word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The bench builds the block with 8 request lines and 4 vector slots. Sources 5, 6 and 7 are mapped to slots 1, 3 and 0, while slot 2 stays disabled. Source 2 has no slot, so it takes the default path, and source 3 is fast-routed. With only four slots and a default level, the bench can walk a complete nesting chain of default, then a low slot, then a high slot, and unwind it ack by ack. Along the way it checks the lock at each level and the re-raise on the final acknowledge.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] OFS_RAW   = 6'h00;
  localparam logic [REG_AW-1:0] OFS_FSTAT = 6'h01;
  localparam logic [REG_AW-1:0] OFS_NSTAT = 6'h02;
  localparam logic [REG_AW-1:0] OFS_FSEL  = 6'h03;
  localparam logic [REG_AW-1:0] OFS_ENSET = 6'h04;
  localparam logic [REG_AW-1:0] OFS_ENCLR = 6'h05;
  localparam logic [REG_AW-1:0] OFS_SWSET = 6'h06;
  localparam logic [REG_AW-1:0] OFS_SWCLR = 6'h07;
  localparam logic [REG_AW-1:0] OFS_VEC   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_DEF   = 6'h09;
  // upper two offset bits pick a slot page, lower four the slot
  localparam logic [1:0] PAGE_SADDR = 2'b10;
  localparam logic [1:0] PAGE_SCTL  = 2'b11;
  localparam int CTL_EN_BIT = 8;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int SEL_W  = 5,
  parameter int LVL_W  = 5
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SLOT-1:0]            slot_en_i,
  input  logic [N_SLOT-1:0][SEL_W-1:0] slot_src_i,
  output logic [LVL_W-1:0]             lvl_o
);
  logic [N_SLOT-1:0] hit;
  logic [N_SRC-1:0]  covered;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_hit
    assign hit[g] = slot_en_i[g] & req_i[slot_src_i[g]];
  end

  always_comb begin
    covered = '0;
    for (int s = 0; s < N_SRC; s++) begin
      for (int i = 0; i < N_SLOT; i++) begin
        if (slot_en_i[i] && (slot_src_i[i] == SEL_W'(s))) covered[s] = 1'b1;
      end
    end
  end

  // lowest-numbered hitting slot wins; default ranks below all slots
  always_comb begin
    lvl_o = LVL_W'(N_SLOT + 1);
    if (|(req_i & ~covered)) lvl_o = LVL_W'(N_SLOT);
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (hit[i]) lvl_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/pvic_nest.sv
module pvic_nest #(
  parameter int N_SLOT = 16,
  parameter int LVL_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] cur_o,
  output logic [LVL_W-1:0] cur_nxt_o
);
  localparam int DEPTH = N_SLOT + 1;
  localparam int PW    = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(N_SLOT + 1);

  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [PW-1:0]    ptr_q, ptr_nxt;
  logic [LVL_W-1:0] cur_q, cur_nxt, top_val;
  logic             do_push;

  always_comb begin
    top_val = LVL_IDLE;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_q == PW'(i + 1)) top_val = stk_q[i];
    end
  end

  always_comb begin
    cur_nxt = cur_q;
    ptr_nxt = ptr_q;
    do_push = 1'b0;
    if (pop_i) begin
      cur_nxt = top_val;
      if (ptr_q != '0) ptr_nxt = ptr_q - 1'b1;
    end else if (push_i && (ptr_q < PW'(DEPTH))) begin
      cur_nxt = lvl_i;
      ptr_nxt = ptr_q + 1'b1;
      do_push = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LVL_IDLE;
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_IDLE;
    end else begin
      cur_q <= cur_nxt;
      ptr_q <= ptr_nxt;
      for (int i = 0; i < DEPTH; i++) begin
        if (do_push && (ptr_q == PW'(i))) stk_q[i] <= cur_q;
      end
    end
  end

  assign cur_o     = cur_q;
  assign cur_nxt_o = cur_nxt;
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int LVL_W = $clog2(N_SLOT + 2);

  logic rst_n;
  logic [N_SRC-1:0] src_s;
  pvic_sync #(.W(1)) u_rst_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n));
  pvic_sync #(.W(N_SRC)) u_src_sync (.clk_i(clk_i), .rst_ni(rst_n), .d_i(irq_src_i), .q_o(src_s));

  logic [N_SRC-1:0]              en_q, en_nxt, soft_q, soft_nxt, fsel_q, fsel_nxt;
  logic [DATA_W-1:0]             def_q, def_nxt;
  logic [N_SLOT-1:0][DATA_W-1:0] saddr_q;
  logic [N_SLOT-1:0][SEL_W-1:0]  ssrc_q;
  logic [N_SLOT-1:0]             sen_q, saddr_we, sctl_we;
  logic                          fiq_q, irq_q, fiq_nxt, irq_nxt;

  logic wr, rd, rd_vec, ack, push;
  logic [N_SRC-1:0] raw, act, fast_act, norm_act;
  logic [LVL_W-1:0] cand_lvl, cur_lvl, cur_nxt, sel_lvl;
  logic [DATA_W-1:0] vec_val;

  assign wr     = bus_sel_i & bus_wr_i;
  assign rd     = bus_sel_i & bus_rd_i;
  assign rd_vec = rd && (bus_addr_i == OFS_VEC);
  assign ack    = wr && (bus_addr_i == OFS_VEC);

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot_we
    assign saddr_we[g] = wr && (bus_addr_i[5:4] == PAGE_SADDR) && (bus_addr_i[3:0] == 4'(g));
    assign sctl_we[g]  = wr && (bus_addr_i[5:4] == PAGE_SCTL)  && (bus_addr_i[3:0] == 4'(g));
  end

  assign raw      = src_s | soft_q;
  assign act      = raw & en_q;
  assign fast_act = act & fsel_q;
  assign norm_act = act & ~fsel_q;

  pvic_arb #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .SEL_W(SEL_W), .LVL_W(LVL_W)) u_arb (
    .req_i(norm_act), .slot_en_i(sen_q), .slot_src_i(ssrc_q), .lvl_o(cand_lvl));

  assign push = rd_vec && (cand_lvl < cur_lvl);

  pvic_nest #(.N_SLOT(N_SLOT), .LVL_W(LVL_W)) u_nest (
    .clk_i(clk_i), .rst_ni(rst_n), .push_i(push), .pop_i(ack),
    .lvl_i(cand_lvl), .cur_o(cur_lvl), .cur_nxt_o(cur_nxt));

  // vector shown: pending winner if it may preempt, otherwise the level in service
  always_comb begin
    sel_lvl = (cand_lvl < cur_lvl) ? cand_lvl : cur_lvl;
    vec_val = def_q;
    for (int k = 0; k < N_SLOT; k++) begin
      if (sel_lvl == LVL_W'(k)) vec_val = saddr_q[k];
    end
  end

  always_comb begin
    en_nxt   = en_q;
    soft_nxt = soft_q;
    fsel_nxt = fsel_q;
    def_nxt  = def_q;
    if (wr) begin
      case (bus_addr_i)
        OFS_ENSET: en_nxt   = en_q | bus_wdata_i[N_SRC-1:0];
        OFS_ENCLR: en_nxt   = en_q & ~bus_wdata_i[N_SRC-1:0];
        OFS_SWSET: soft_nxt = soft_q | bus_wdata_i[N_SRC-1:0];
        OFS_SWCLR: soft_nxt = soft_q & ~bus_wdata_i[N_SRC-1:0];
        OFS_FSEL:  fsel_nxt = bus_wdata_i[N_SRC-1:0];
        OFS_DEF:   def_nxt  = bus_wdata_i;
        default: ;
      endcase
    end
    fiq_nxt = |fast_act;
    irq_nxt = cand_lvl < cur_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      soft_q <= '0;
      fsel_q <= '0;
      def_q  <= '0;
      fiq_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      soft_q <= soft_nxt;
      fsel_q <= fsel_nxt;
      def_q  <= def_nxt;
      fiq_q  <= fiq_nxt;
      irq_q  <= irq_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      saddr_q <= '0;
      ssrc_q  <= '0;
      sen_q   <= '0;
    end else begin
      for (int k = 0; k < N_SLOT; k++) begin
        if (saddr_we[k]) saddr_q[k] <= bus_wdata_i;
        if (sctl_we[k]) begin
          sen_q[k]  <= bus_wdata_i[CTL_EN_BIT];
          ssrc_q[k] <= bus_wdata_i[SEL_W-1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_RAW:   bus_rdata_o = DATA_W'(raw);
      OFS_FSTAT: bus_rdata_o = DATA_W'(fast_act);
      OFS_NSTAT: bus_rdata_o = DATA_W'(norm_act);
      OFS_FSEL:  bus_rdata_o = DATA_W'(fsel_q);
      OFS_ENSET: bus_rdata_o = DATA_W'(en_q);
      OFS_SWSET: bus_rdata_o = DATA_W'(soft_q);
      OFS_VEC:   bus_rdata_o = vec_val;
      OFS_DEF:   bus_rdata_o = def_q;
      default: begin
        for (int k = 0; k < N_SLOT; k++) begin
          if (bus_addr_i[3:0] == 4'(k)) begin
            if (bus_addr_i[5:4] == PAGE_SADDR) bus_rdata_o = saddr_q[k];
            if (bus_addr_i[5:4] == PAGE_SCTL) begin
              bus_rdata_o[CTL_EN_BIT] = sen_q[k];
              bus_rdata_o[SEL_W-1:0]  = ssrc_q[k];
            end
          end
        end
      end
    endcase
  end

  assign fiq_o = fiq_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int N_SLOT = 16
) (
  input logic                          clk_i,
  input logic                          rst_n,
  input logic                          irq_o,
  input logic                          fiq_o,
  input logic                          rd_vec,
  input logic                          ack,
  input logic                          push,
  input logic                          en_any,
  input logic                          stk_empty,
  input logic [$clog2(N_SLOT+2)-1:0]   cand_lvl,
  input logic [$clog2(N_SLOT+2)-1:0]   cur_lvl
);
  localparam int LVL_W = $clog2(N_SLOT + 2);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(N_SLOT + 1);

  AST_NO_ENABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_any |=> (!fiq_o && !irq_o)); // R2
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> $past(cand_lvl != LVL_IDLE)); // R5
  AST_CLAIM_DROPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_vec && !ack && irq_o) |=> !irq_o); // R6
  AST_PREEMPT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_n)
    push |=> (cur_lvl < $past(cur_lvl))); // R7
  AST_ACK_RERAISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack && stk_empty && (cand_lvl != LVL_IDLE)) |=> irq_o); // R8
endmodule

bind pvic_top pvic_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
  .rd_vec(rd_vec), .ack(ack), .push(push), .en_any(|en_q),
  .stk_empty(u_nest.ptr_q == '0), .cand_lvl(cand_lvl), .cur_lvl(cur_lvl));

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;
  int nchk = 0, nerr = 0;
  logic [7:0] en_exp = '0;

  localparam logic [5:0] A_RAW = 6'h00, A_FST = 6'h01, A_NST = 6'h02, A_FSEL = 6'h03,
    A_ENS = 6'h04, A_ENC = 6'h05, A_SWS = 6'h06, A_SWC = 6'h07, A_VEC = 6'h08, A_DEF = 6'h09;
  localparam logic [31:0] V0 = 32'h0000_00A0, V1 = 32'h1111_0100, V3 = 32'h3333_0300,
    VD = 32'h0000_DEF0;

  always #5 clk = ~clk;

  pvic_top #(.N_SRC(8), .N_SLOT(4), .DATA_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; rd = 1'b1; addr = a; #1 d = rdata;
    @(posedge clk); #1; sel = 1'b0; rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 fiq", {31'd0, fiq}, 32'd0);
    bus_read(A_ENS, d); check("R1 enables", d, 32'd0);
    bus_read(A_SWS, d); check("R1 triggers", d, 32'd0);
    bus_read(A_FSEL, d); check("R1 fast select", d, 32'd0);
    bus_read(6'h30, d); check("R1 slot ctl", d, 32'd0);
    bus_read(A_VEC, d); check("R1 vector", d, 32'd0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    bus_write(A_ENS, 32'h05); bus_read(A_ENS, d); check("R9 set", d, 32'h05);
    bus_write(A_ENS, 32'h02); bus_read(A_ENS, d); check("R9 set keeps", d, 32'h07);
    bus_write(A_ENC, 32'h04); bus_read(A_ENS, d); check("R9 clear", d, 32'h03);
    bus_write(A_ENC, 32'hFF); bus_read(A_ENS, d); check("R9 clear all", d, 32'h00);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    bus_write(A_ENS, 32'h03); en_exp = 8'h03;
    @(negedge clk); src[0] = 1'b1;
    @(posedge clk); @(negedge clk); check("R3 edge k", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk); check("R3 edge k+1", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk); check("R3 edge k+2", {31'd1 & 32'd0, irq}, 32'd1);
    src[0] = 1'b0; settle(4);
    check("R3 released", {31'd0, irq}, 32'd0);
    bus_write(A_SWS, 32'h02);
    check("R3 sw edge k", {31'd0, irq}, 32'd0);
    @(posedge clk); #1; check("R3 sw edge k+1", {31'd0, irq}, 32'd1);
    bus_read(A_RAW, d); check("R10 raw shows trigger", d, 32'h02);
    bus_write(A_SWC, 32'h02); settle(2);
    check("R10 trigger cleared", {31'd0, irq}, 32'd0);
    bus_read(A_SWS, d); check("R10 trigger readback", d, 32'h00);
  endtask

  task automatic t_steer;
    logic [31:0] d;
    bus_write(A_ENS, 32'h0C); en_exp = en_exp | 8'h0C;
    bus_write(A_FSEL, 32'h08);
    @(negedge clk); src[2] = 1'b1; settle(4);
    check("R2 normal irq", {31'd0, irq}, 32'd1);
    check("R2 normal fiq", {31'd0, fiq}, 32'd0);
    bus_read(A_NST, d); check("R11 normal status", d, 32'h04);
    bus_read(A_FST, d); check("R11 fast status empty", d, 32'h00);
    src[2] = 1'b0; src[3] = 1'b1; settle(4);
    check("R2 fast fiq", {31'd0, fiq}, 32'd1);
    check("R2 fast irq", {31'd0, irq}, 32'd0);
    bus_read(A_FST, d); check("R11 fast status", d, 32'h08);
    src[3] = 1'b0; src[4] = 1'b1; settle(4);
    check("R2 disabled irq", {31'd0, irq}, 32'd0);
    check("R2 disabled fiq", {31'd0, fiq}, 32'd0);
    bus_read(A_RAW, d); check("R10 raw disabled line", d, 32'h10);
    src[4] = 1'b0; settle(3);
  endtask

  task automatic t_vector;
    logic [31:0] d;
    bus_write(6'h20, V0); bus_write(6'h30, 32'h107);
    bus_write(6'h21, V1); bus_write(6'h31, 32'h105);
    bus_write(6'h23, V3); bus_write(6'h33, 32'h106);
    bus_write(A_ENS, 32'hE0); en_exp = en_exp | 8'hE0;
    bus_read(6'h31, d); check("R4 slot ctl readback", d, 32'h105);
    @(negedge clk); src[5] = 1'b1; src[6] = 1'b1; settle(4);
    check("R4 raised", {31'd0, irq}, 32'd1);
    bus_read(A_VEC, d); check("R4 lowest slot wins", d, V1);
    check("R6 claim drops irq", {31'd0, irq}, 32'd0);
    settle(2); check("R6 lower held back", {31'd0, irq}, 32'd0);
    src[5] = 1'b0; settle(4);
    bus_write(A_VEC, 32'h0); check("R8 ack reraises", {31'd0, irq}, 32'd1);
    bus_read(A_VEC, d); check("R4 next slot", d, V3);
    src[6] = 1'b0; settle(4);
    bus_write(A_VEC, 32'hFFFF_FFFF); check("R8 ack idle", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_nest;
    logic [31:0] d;
    bus_write(A_DEF, VD);
    @(negedge clk); src[2] = 1'b1; settle(4);
    bus_read(A_VEC, d); check("R5 default address", d, VD);
    src[6] = 1'b1; settle(4);
    check("R7 slot preempts default", {31'd0, irq}, 32'd1);
    bus_read(A_VEC, d); check("R7 preempt vector", d, V3);
    check("R6 claim drops", {31'd0, irq}, 32'd0);
    src[5] = 1'b1; settle(4);
    check("R7 higher preempts", {31'd0, irq}, 32'd1);
    bus_read(A_VEC, d); check("R7 higher vector", d, V1);
    src[5] = 1'b0; settle(4);
    bus_write(A_VEC, 32'h0); check("R7 restored level blocks", {31'd0, irq}, 32'd0);
    settle(3); check("R7 still blocked", {31'd0, irq}, 32'd0);
    src[6] = 1'b0; settle(4);
    bus_write(A_VEC, 32'h0); check("R7 default level blocks", {31'd0, irq}, 32'd0);
    bus_write(A_VEC, 32'h0); check("R8 reraise default", {31'd0, irq}, 32'd1);
    bus_read(A_VEC, d); check("R5 default again", d, VD);
    src[2] = 1'b0; settle(4);
    bus_write(A_VEC, 32'h0); check("R8 final idle", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(4);
    t_reset;
    t_enable;
    t_latency;
    t_steer;
    t_vector;
    t_nest;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule